// File: doc/BRIEF.md
# Coordinate-Encoded Instruction Execution Unit

This unit executes one instruction per cycle. An instruction arrives as a single 16-bit coordinate that packs three indices arithmetically rather than as bit fields: a subject index (0..18), an operation index (0..20) and a destination slot (0..27), combined as `subject*588 + operation*28 + slot`. Alongside the coordinate come an inherit bit, which reuses the subject of the previous open chain, and a 16-bit operand with its own present bit. The unit divides the coordinate back into its indices. It applies the operation to a file of 16-bit subject registers and a one-bit flag. The result is then either kept internally (slot 0) or driven out to one of 27 output ports (slots 1..27), each with a one-cycle write strobe.

A write to a port closes the subject chain. An inherit request while the chain is closed is rejected with a one-cycle error pulse and has no effect. Coordinates outside the legal range are rejected the same way. Subjects and operations whose semantics this unit does not implement raise a third error pulse. The instruction input is a valid/ready stream. `in_ready` is held high, so there is no back-pressure. A beat is taken on every rising edge where `in_valid` is high, and nothing happens on cycles where it is low. All results, strobes and error pulses appear in the cycle after the instruction is accepted.

Top module: `coord_exec_unit`

## Requirements
- R1: `in_ready` is always 1; an accepted coordinate `a` is split into subject `a/588`, operation `(a%588)/28` and slot `a%28`; all effects appear one cycle after acceptance, and a cycle without `in_valid` produces no strobe and no error pulse.
- R2: A coordinate of 11172 or more is illegal: `err_illegal` pulses for one cycle and no register, flag, chain state or port changes.
- R3: Operation 0 adds one, operation 1 subtracts one, operation 2 doubles; all arithmetic wraps modulo 2^16.
- R4: Operation 8 loads the operand, or zero when the operand is absent. Operations 10, 11 and 12 apply bitwise AND, OR and XOR with the operand (zero when absent). Operation 13 inverts the register bitwise.
- R5: Operation 4 sets the flag to (register > operand) and operation 5 to (register < operand), both strict, with an absent operand read as zero; the register is unchanged; a port destination receives the flag result as 0 or 1.
- R6: With slot 0 the result is written back to the subject register, no strobe fires, and the chain opens on that subject; a following instruction with the inherit bit set acts on that subject whatever the coordinate's subject field holds.
- R7: With slot k in 1..27 the result is written back to the subject register and also to port k, whose strobe (`port_stb` bit k-1) is high for exactly one cycle; the chain is then closed.
- R8: An instruction with the inherit bit set while the chain is closed pulses `err_chain` for one cycle and changes no state and no port.
- R9: Operation 9 clears the subject register; with slot 0 no port changes, and with a port slot that port is driven to zero.
- R10: With subject 5 (the flag subject) and a port slot, the port write happens only if the flag is 1 before the instruction; the register update and chain closing still happen.
- R11: Subjects 12, 15, 17, 18 and operations 3, 6, 7 and 14..20 are unsupported: `err_unsup` pulses for one cycle and no state or port changes.
- R12: After reset all subject registers, ports, strobes, error pulses and the flag are zero and the chain is closed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction beat present |
| in_ready | output | 1 | Always high; no back-pressure |
| in_coord | input | 16 | Packed subject/operation/slot coordinate |
| in_inherit | input | 1 | Reuse the subject of the open chain |
| in_operand | input | 16 | Operand value |
| in_operand_vld | input | 1 | Operand present; when low the operand reads as zero |
| port_q | output | 432 | Port k data at bits [(k-1)*16 +: 16], k = 1..27 |
| port_stb | output | 27 | Bit k-1 pulses when port k is written |
| err_chain | output | 1 | Inherit attempted on a closed chain |
| err_illegal | output | 1 | Coordinate out of range |
| err_unsup | output | 1 | Subject or operation not implemented |

## Verification
The embedded properties watch, every cycle, that at most one strobe and at most one error pulse fire, that idle cycles stay quiet, and that rejected instructions leave the flag and chain state untouched. They also check that the flag moves only after a comparison, that port writes close the chain while slot-0 results open it, and that a gated flag-subject write produces no strobe. The scenarios alone show the arithmetic values: wrap-around at both ends, the strict comparisons at equal operands, and inheritance overriding the coordinate's subject field. They also show that register contents survive a rejected instruction, which the bench reads back through a later port write.

// File: rtl/cx_pkg.sv
package cx_pkg;

  localparam int FLAG_SUBJ = 5;

  typedef enum logic [4:0] {
    OP_INC   = 5'd0,  OP_DEC   = 5'd1,  OP_DBL   = 5'd2,  OP_SLOW  = 5'd3,
    OP_ABOVE = 5'd4,  OP_BELOW = 5'd5,  OP_TURBO = 5'd6,  OP_KILL  = 5'd7,
    OP_LOAD  = 5'd8,  OP_CUT   = 5'd9,  OP_AND   = 5'd10, OP_OR    = 5'd11,
    OP_XOR   = 5'd12, OP_INV   = 5'd13, OP_LOG   = 5'd14, OP_SQR   = 5'd15,
    OP_ROOT  = 5'd16, OP_WGT   = 5'd17, OP_FLT   = 5'd18, OP_UNI   = 5'd19,
    OP_MOVE  = 5'd20
  } op_e;

  function automatic logic op_supported(input logic [4:0] g);
    case (g)
      OP_INC, OP_DEC, OP_DBL, OP_ABOVE, OP_BELOW, OP_LOAD, OP_CUT,
      OP_AND, OP_OR, OP_XOR, OP_INV: op_supported = 1'b1;
      default:                       op_supported = 1'b0;
    endcase
  endfunction

  function automatic logic subj_supported(input logic [4:0] s);
    subj_supported = !(s == 5'd12 || s == 5'd15 || s == 5'd17 || s == 5'd18);
  endfunction

endpackage

// File: rtl/cx_coord_split.sv
module cx_coord_split #(
  parameter int AW    = 16,
  parameter int NSUBJ = 19,
  parameter int NSIG  = 21,
  parameter int NSLOT = 28,
  localparam int SW     = $clog2(NSUBJ),
  localparam int GW     = $clog2(NSIG),
  localparam int OW     = $clog2(NSLOT),
  localparam int STRIDE = NSIG * NSLOT,
  localparam int LIMIT  = NSUBJ * STRIDE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] coord,
  output logic [SW-1:0] subj,
  output logic [GW-1:0] sig,
  output logic [OW-1:0] slot,
  output logic          legal
);

  logic [AW-1:0] subj_full, rem_full, sig_full, slot_full;

  always_comb begin
    subj_full = coord / AW'(STRIDE);
    rem_full  = coord % AW'(STRIDE);
    sig_full  = rem_full / AW'(NSLOT);
    slot_full = rem_full % AW'(NSLOT);
    legal     = coord < AW'(LIMIT);
    subj      = subj_full[SW-1:0];
    sig       = sig_full[GW-1:0];
    slot      = slot_full[OW-1:0];
  end

  AST_SPLIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    legal |-> (subj_full < AW'(NSUBJ) && sig_full < AW'(NSIG) && slot_full < AW'(NSLOT))); // R1

  AST_SPLIT_ROUNDTRIP: assert property (@(posedge clk) disable iff (!rst_n)
    legal |-> (32'(subj) * STRIDE + 32'(sig) * NSLOT + 32'(slot) == 32'(coord))); // R1

endmodule

// File: rtl/cx_op_unit.sv
module cx_op_unit
  import cx_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  op_e          op,
  output logic [W-1:0] res,
  output logic         is_cmp
);

  always_comb begin
    is_cmp = 1'b0;
    res    = opa;
    case (op)
      OP_INC:   res = opa + W'(1);
      OP_DEC:   res = opa - W'(1);
      OP_DBL:   res = {opa[W-2:0], 1'b0};
      OP_LOAD:  res = opb;
      OP_CUT:   res = '0;
      OP_AND:   res = opa & opb;
      OP_OR:    res = opa | opb;
      OP_XOR:   res = opa ^ opb;
      OP_INV:   res = ~opa;
      OP_ABOVE: begin is_cmp = 1'b1; res = W'(opa > opb); end
      OP_BELOW: begin is_cmp = 1'b1; res = W'(opa < opb); end
      default:  res = opa;
    endcase
  end

endmodule

// File: rtl/cx_port_bank.sv
module cx_port_bank #(
  parameter int W     = 16,
  parameter int NSLOT = 28,
  localparam int OW    = $clog2(NSLOT),
  localparam int NPORT = NSLOT - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OW-1:0]    wr_slot,
  input  logic [W-1:0]     wr_data,
  output logic [NPORT*W-1:0] port_q,
  output logic [NPORT-1:0] port_stb
);

  for (genvar k = 1; k < NSLOT; k++) begin : g_port
    logic [W-1:0] q_r;
    logic         s_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_r <= '0;
        s_r <= 1'b0;
      end else begin
        s_r <= wr_en && (wr_slot == OW'(k));
        if (wr_en && (wr_slot == OW'(k))) q_r <= wr_data;
      end
    end
    assign port_q[(k-1)*W +: W] = q_r;
    assign port_stb[k-1]        = s_r;
  end

  AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(port_stb)); // R7

  AST_STB_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_slot != '0) |=> (port_stb != '0)); // R7

endmodule

// File: rtl/coord_exec_unit.sv
module coord_exec_unit
  import cx_pkg::*;
#(
  parameter int W     = 16,
  parameter int AW    = 16,
  parameter int NSUBJ = 19,
  parameter int NSIG  = 21,
  parameter int NSLOT = 28,
  localparam int SW    = $clog2(NSUBJ),
  localparam int GW    = $clog2(NSIG),
  localparam int OW    = $clog2(NSLOT),
  localparam int NPORT = NSLOT - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [AW-1:0]      in_coord,
  input  logic               in_inherit,
  input  logic [W-1:0]       in_operand,
  input  logic               in_operand_vld,
  output logic [NPORT*W-1:0] port_q,
  output logic [NPORT-1:0]   port_stb,
  output logic               err_chain,
  output logic               err_illegal,
  output logic               err_unsup
);

  logic [SW-1:0] d_subj, eff_subj, rd_idx, ctx_subj;
  logic [GW-1:0] d_sig;
  logic [OW-1:0] d_slot;
  logic          d_legal, ctx_open, flag_q;
  logic          chain_bad, sup, exec_en, gate, port_wr, is_cmp;
  logic [W-1:0]  regs [NSUBJ];
  logic [W-1:0]  opa, opb, alu_res;

  assign in_ready = 1'b1;

  cx_coord_split #(.AW(AW), .NSUBJ(NSUBJ), .NSIG(NSIG), .NSLOT(NSLOT)) u_split (
    .clk(clk), .rst_n(rst_n), .coord(in_coord),
    .subj(d_subj), .sig(d_sig), .slot(d_slot), .legal(d_legal));

  always_comb begin
    eff_subj  = in_inherit ? ctx_subj : d_subj;
    chain_bad = in_inherit && !ctx_open;
    sup       = op_supported(5'(d_sig)) && subj_supported(5'(eff_subj));
    exec_en   = in_valid && d_legal && !chain_bad && sup;
    rd_idx    = (eff_subj < SW'(NSUBJ)) ? eff_subj : '0;
    opa       = regs[rd_idx];
    opb       = in_operand_vld ? in_operand : '0;
    gate      = (eff_subj != SW'(FLAG_SUBJ)) || flag_q;
    port_wr   = exec_en && (d_slot != '0) && gate;
  end

  cx_op_unit #(.W(W)) u_op (
    .opa(opa), .opb(opb), .op(op_e'(d_sig)), .res(alu_res), .is_cmp(is_cmp));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSUBJ; i++) regs[i] <= '0;
      flag_q      <= 1'b0;
      ctx_open    <= 1'b0;
      ctx_subj    <= '0;
      err_chain   <= 1'b0;
      err_illegal <= 1'b0;
      err_unsup   <= 1'b0;
    end else begin
      err_illegal <= in_valid && !d_legal;
      err_chain   <= in_valid && d_legal && chain_bad;
      err_unsup   <= in_valid && d_legal && !chain_bad && !sup;
      if (exec_en) begin
        if (is_cmp) flag_q <= alu_res[0];
        else        regs[rd_idx] <= alu_res;
        ctx_open <= (d_slot == '0);
        ctx_subj <= eff_subj;
      end
    end
  end

  cx_port_bank #(.W(W), .NSLOT(NSLOT)) u_ports (
    .clk(clk), .rst_n(rst_n), .wr_en(port_wr), .wr_slot(d_slot),
    .wr_data(alu_res), .port_q(port_q), .port_stb(port_stb));

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (port_stb == '0 && !err_chain && !err_illegal && !err_unsup)); // R1

  AST_ONE_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({err_chain, err_illegal, err_unsup}) <= 1); // R11

  AST_ILLEGAL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    err_illegal |-> (flag_q == $past(flag_q) && ctx_open == $past(ctx_open) && port_stb == '0)); // R2

  AST_CHAIN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    err_chain |-> (flag_q == $past(flag_q) && !ctx_open && port_stb == '0)); // R8

  AST_UNSUP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    err_unsup |-> (flag_q == $past(flag_q) && ctx_open == $past(ctx_open) && port_stb == '0)); // R11

  AST_FLAG_ONLY_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q != $past(flag_q)) |-> $past(exec_en && is_cmp)); // R5

  AST_HOLD_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && d_slot == '0) |=> (ctx_open && port_stb == '0)); // R6

  AST_PORT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (port_stb != '0) |-> !ctx_open); // R7

  AST_FLAG_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && d_slot != '0 && eff_subj == SW'(FLAG_SUBJ) && !flag_q) |=> (port_stb == '0)); // R10

  AST_CUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && d_sig == GW'(OP_CUT)) |=> (port_q[(32'($past(d_slot)) - 1) * W +: W] == '0)); // R9

endmodule

// File: tb/coord_exec_unit_test.sv
module coord_exec_unit_test;

  typedef struct {
    logic [26:0] stb;
    logic [15:0] data;
    logic [2:0]  err;   // {chain, illegal, unsup}
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [15:0] in_coord = '0;
  logic in_inherit = 1'b0;
  logic [15:0] in_operand = '0;
  logic in_operand_vld = 1'b0;
  logic [431:0] port_q;
  logic [26:0] port_stb;
  logic err_chain, err_illegal, err_unsup;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  exp_t q[$];

  logic [15:0] m_reg [19];
  logic m_flag = 1'b0;
  logic m_open = 1'b0;
  int   m_subj = 0;

  always #2 clk = ~clk;

  coord_exec_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_coord(in_coord), .in_inherit(in_inherit), .in_operand(in_operand),
    .in_operand_vld(in_operand_vld), .port_q(port_q), .port_stb(port_stb),
    .err_chain(err_chain), .err_illegal(err_illegal), .err_unsup(err_unsup));

  function automatic logic [15:0] port_of(input int k);
    return port_q[(k-1)*16 +: 16];
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic bit unsup_subj(input int s);
    return s == 12 || s == 15 || s == 17 || s == 18;
  endfunction

  function automatic bit unsup_op(input int g);
    return g == 3 || g == 6 || g == 7 || g >= 14;
  endfunction

  task automatic drive(input logic [15:0] a, input bit inh, input logic [15:0] p, input bit pv);
    @(posedge clk); #1;
    in_valid = 1'b1; in_coord = a; in_inherit = inh;
    in_operand = p; in_operand_vld = pv;
  endtask

  task automatic send(input int s, input int g, input int o, input bit inh,
                      input logic [15:0] p, input bit pv, input string tag);
    exp_t e;
    int eff;
    logic [15:0] v, pp, r;
    bit cmp;
    e.stb = '0; e.data = '0; e.err = '0; e.tag = tag;
    if (inh && !m_open) e.err = 3'b100;
    else begin
      eff = inh ? m_subj : s;
      if (unsup_subj(eff) || unsup_op(g)) e.err = 3'b001;
      else begin
        v = m_reg[eff]; pp = pv ? p : 16'h0; cmp = 1'b0;
        case (g)
          0: r = v + 16'd1;
          1: r = v - 16'd1;
          2: r = v << 1;
          4: begin cmp = 1'b1; r = {15'b0, v > pp}; end
          5: begin cmp = 1'b1; r = {15'b0, v < pp}; end
          8: r = pp;
          9: r = 16'h0;
          10: r = v & pp;
          11: r = v | pp;
          12: r = v ^ pp;
          default: r = ~v;
        endcase
        if (o != 0 && (eff != 5 || m_flag)) begin
          e.stb[o-1] = 1'b1; e.data = r;
        end
        if (cmp) m_flag = r[0];
        else m_reg[eff] = r;
        m_open = (o == 0);
        m_subj = eff;
      end
    end
    q.push_back(e);
    drive(16'(s*588 + g*28 + o), inh, p, pv);
  endtask

  task automatic send_raw(input logic [15:0] a, input string tag);
    exp_t e;
    e.stb = '0; e.data = '0; e.err = 3'b010; e.tag = tag;
    q.push_back(e);
    drive(a, 1'b0, 16'h0, 1'b0);
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; in_valid = 1'b0; end
  endtask

  // Monitor: pops one expectation per accepted beat and compares after the edge.
  initial begin
    forever begin
      bit v;
      exp_t e;
      @(negedge clk);
      v = in_valid && rst_n;
      @(posedge clk); #1;
      if (v) begin
        if (q.size() == 0) check(1'b0, "R1", "unexpected beat", 0, 0);
        else begin
          int k;
          e = q.pop_front();
          check(port_stb == e.stb, e.tag, "strobes", 32'(port_stb), 32'(e.stb));
          check({err_chain, err_illegal, err_unsup} == e.err, e.tag, "errors",
                32'({err_chain, err_illegal, err_unsup}), 32'(e.err));
          k = 0;
          for (int i = 0; i < 27; i++) if (e.stb[i]) k = i + 1;
          if (k != 0) check(port_of(k) == e.data, e.tag, "port data", 32'(port_of(k)), 32'(e.data));
        end
      end else if (rst_n) begin
        check(port_stb == '0 && !err_chain && !err_illegal && !err_unsup, "R1",
              "idle quiet", 32'({port_stb, err_chain, err_illegal, err_unsup}), 0);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 19; i++) m_reg[i] = 16'h0;
    repeat (3) @(posedge clk);
    #1;
    // R12: reset state
    check(port_q == '0, "R12", "ports after reset", 32'(port_q[31:0]), 0);
    check(port_stb == '0 && !err_chain && !err_illegal && !err_unsup, "R12", "pulses after reset", 32'(port_stb), 0);
    check(in_ready == 1'b1, "R1", "ready high", 32'(in_ready), 1);
    rst_n = 1'b1;
    idle(2);
    // R8: inherit right after reset (chain closed)
    send(0, 0, 0, 1'b1, 16'h0, 1'b0, "R8");
    // R6/R3: load, chain, double to port
    send(0, 8, 0, 1'b0, 16'd100, 1'b1, "R4");
    send(0, 0, 0, 1'b1, 16'h0, 1'b0, "R6");
    send(0, 2, 3, 1'b1, 16'h0, 1'b0, "R7");
    send(0, 0, 0, 1'b1, 16'h0, 1'b0, "R8");
    send(0, 11, 1, 1'b0, 16'h0, 1'b1, "R8");
    idle(1);
    // R3: wrap at both ends
    send(1, 1, 4, 1'b0, 16'h0, 1'b0, "R3");
    send(2, 8, 0, 1'b0, 16'h8001, 1'b1, "R3");
    send(2, 2, 6, 1'b1, 16'h0, 1'b0, "R3");
    send(1, 0, 2, 1'b0, 16'h0, 1'b0, "R3");
    // R4: absent operand loads zero; bitwise chain
    send(2, 8, 5, 1'b0, 16'd55, 1'b0, "R4");
    send(3, 8, 0, 1'b0, 16'hF0F0, 1'b1, "R4");
    send(3, 10, 0, 1'b1, 16'hFF00, 1'b1, "R4");
    send(3, 12, 0, 1'b1, 16'h0FF0, 1'b1, "R4");
    send(3, 11, 0, 1'b1, 16'h0003, 1'b1, "R4");
    send(3, 13, 7, 1'b1, 16'h0000, 1'b1, "R4");
    idle(2);
    // R5 / R10: strict compares and flag gating
    send(0, 4, 0, 1'b0, 16'd202, 1'b1, "R5");
    send(5, 8, 8, 1'b0, 16'd7, 1'b1, "R10");
    send(0, 4, 9, 1'b0, 16'd201, 1'b1, "R5");
    send(5, 11, 8, 1'b0, 16'h0, 1'b0, "R10");
    send(0, 5, 12, 1'b0, 16'h0, 1'b0, "R5");
    send(4, 5, 13, 1'b0, 16'd1, 1'b1, "R5");
    send(0, 5, 14, 1'b0, 16'd202, 1'b1, "R5");
    // R9: cut internally and on a port
    send(6, 8, 10, 1'b0, 16'd9, 1'b1, "R9");
    send(6, 9, 10, 1'b0, 16'h0, 1'b0, "R9");
    send(0, 9, 0, 1'b0, 16'h0, 1'b0, "R9");
    send(0, 11, 1, 1'b0, 16'h0, 1'b0, "R9");
    idle(1);
    // R2: illegal coordinates, state preserved
    send(7, 8, 0, 1'b0, 16'd42, 1'b1, "R6");
    send_raw(16'd11172, "R2");
    send_raw(16'hFFFF, "R2");
    send(7, 0, 15, 1'b1, 16'h0, 1'b0, "R2");
    // R11: unsupported subjects and operations
    send(1, 8, 0, 1'b0, 16'd5, 1'b1, "R6");
    send(12, 8, 0, 1'b0, 16'd1, 1'b1, "R11");
    send(1, 14, 0, 1'b1, 16'h0, 1'b0, "R11");
    send(18, 20, 27, 1'b0, 16'h0, 1'b0, "R11");
    send(15, 0, 0, 1'b0, 16'h0, 1'b0, "R11");
    // R6: inherit overrides subject field
    send(0, 0, 11, 1'b1, 16'h0, 1'b0, "R6");
    // R7: top slot, high legal subject
    send(14, 8, 27, 1'b0, 16'hBEEF, 1'b1, "R7");
    send(14, 1, 16, 1'b0, 16'h0, 1'b0, "R7");
    idle(3);
    check(q.size() == 0, "R1", "all beats answered", 32'(q.size()), 0);
    check(port_of(27) == 16'hBEEF, "R7", "port held", 32'(port_of(27)), 32'hBEEF);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule